// File: doc/BRIEF.md
# Programmable Watchdog Timer Unit

This block is a hardware guard against runaway software. Once software enables it, a 15-bit up-counter advances at a prescaled rate. If software does not refresh it in time, the counter rolls over. The block then issues a one-cycle reset request and records, in a sticky flag, that the last reset came from the watchdog and not from outside.

Software talks to the block through a narrow register write port. Two registers are reachable through it. The reload register holds a 7-bit time-out value and a rate-select bit. The control register carries a start bit and an arm bit. A refresh only counts when an arm write is followed on the very next cycle by a start write. This makes it unlikely that a stray store will keep a crashed program alive.

A halt input freezes the unit while the system sleeps. After the watchdog has been started, no register write can turn it off again; only a reset can. With a 16 MHz clock the time-out spans roughly 192 µs to 393 ms.

Top module: `wdt_unit`

## Requirements
- R1: After the external reset (`rst` high), `wdt_req_o` and `wdt_cause_o` are low and the watchdog is disabled. Without a start write, no request ever appears.
- R2: Register select `wr_sel_i` = 0 addresses the reload register: bit 7 is the rate select and bits 6:0 are the reload value. `wr_sel_i` = 1 addresses the control register: bit 0 is start and bit 1 is arm. A reload-register write has no effect on the running count until the next refresh.
- R3: A control write with the start bit set, made while the watchdog is disabled, enables it. No later write, including a control write of zero, disables it.
- R4: A refresh is a control write with arm set, followed on the next cycle by a control write with start set, while the watchdog is enabled. It loads counter bits 14:8 from reload bits 6:0, clears counter bits 7:0 and clears the prescaler.
- R5: If the start write does not come on the cycle directly after the arm write, the arm is dropped. A later start-only write does not reload the counter.
- R6: With rate select 0, the counter advances once every 12 enabled, non-halted cycles. With reload value V, the overflow occurs (32768 − 256·V)·12 cycles after the refresh edge; for V = 0x7F this is 3072 cycles.
- R7: With rate select 1, the counter advances once every 192 cycles. For V = 0x7F the overflow occurs 49152 cycles after the refresh edge.
- R8: When the counter increments past 0x7FFF, `wdt_req_o` is high for exactly one cycle, the cycle following that edge.
- R9: `wdt_cause_o` rises together with the request and stays high until the external reset.
- R10: A watchdog overflow clears the enable, the counter, the arm state, the prescaler and the reload register. No further request comes without a new start.
- R11: While `halt_i` is high, the prescaler and the counter hold their values. The overflow is delayed by exactly the number of halted cycles.
- R12: A refresh whose start write lands on the same edge as an overflow takes priority: no request is raised and the counter is reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | External synchronous reset, active high |
| halt_i | input | 1 | Idle/power-down halt; freezes counting |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Register select: 0 reload, 1 control |
| wr_data_i | input | 8 | Write data |
| wdt_req_o | output | 1 | Reset request pulse (registered) |
| wdt_cause_o | output | 1 | Sticky flag: last reset was caused by the watchdog |

## Verification
Two functions can meet on one edge: a refresh and the counter overflow. The bench times an arm/start pair so that the start write is captured on exactly the edge where the counter would pass 0x7FFF. It then judges that no request appears, that the cause flag stays low and that the next overflow arrives a full reload period later. Halt and overflow timing are also combined: the bench shifts the expected overflow edge by the halted length and checks the request cycle-exactly.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    SEL_RELOAD = 1'b0,
    SEL_CTRL   = 1'b1
  } wdt_sel_e;

  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_ARM_BIT   = 1;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs #(
  parameter int DATA_W = 8,
  parameter int REL_W  = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              en_o,
  output logic              refresh_o,
  output logic              slow_sel_o,
  output logic [REL_W-1:0]  reload_o
);
  import wdt_pkg::*;

  logic              en_q;
  logic              arm_q;
  logic [DATA_W-1:0] reload_q;
  logic              ctrl_wr;
  logic              start_wr;
  logic              arm_wr;

  assign ctrl_wr  = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign start_wr = ctrl_wr && wr_data_i[CTRL_START_BIT];
  assign arm_wr   = ctrl_wr && wr_data_i[CTRL_ARM_BIT];

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      en_q     <= 1'b0;
      arm_q    <= 1'b0;
      reload_q <= '0;
    end else begin
      if (start_wr) en_q <= 1'b1;
      arm_q <= arm_wr;
      if (wr_en_i && (wr_sel_i == SEL_RELOAD)) reload_q <= wr_data_i;
    end
  end

  assign en_o       = en_q;
  assign refresh_o  = start_wr && arm_q && en_q;
  assign slow_sel_o = reload_q[DATA_W-1];
  assign reload_o   = reload_q[REL_W-1:0];

  p_enable_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (en_q && !clr_i) |=> en_q);

  p_arm_dropped_r5: assert property (@(posedge clk) disable iff (rst)
    (!arm_wr) |=> !arm_q);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int BASE_DIV = 12,
  parameter int SLOW_DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic run_i,
  input  logic slow_sel_i,
  output logic tick_o
);
  localparam int BASE_W = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;

  logic [BASE_W-1:0] base_q;
  logic              base_tick;

  assign base_tick = run_i && (base_q == BASE_W'(BASE_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clr_i)   base_q <= '0;
    else if (base_tick) base_q <= '0;
    else if (run_i)     base_q <= base_q + 1'b1;
  end

  generate
    if (SLOW_DIV > 1) begin : g_slow
      localparam int SLOW_W = $clog2(SLOW_DIV);
      logic [SLOW_W-1:0] slow_q;
      logic              slow_wrap;

      assign slow_wrap = (slow_q == SLOW_W'(SLOW_DIV - 1));

      always_ff @(posedge clk) begin
        if (rst || clr_i)   slow_q <= '0;
        else if (base_tick) slow_q <= slow_wrap ? '0 : slow_q + 1'b1;
      end

      assign tick_o = base_tick && (!slow_sel_i || slow_wrap);

      p_slow_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !clr_i) |=> (slow_q == $past(slow_q)));
    end else begin : g_noslow
      assign tick_o = base_tick;
    end
  endgenerate

  p_base_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !clr_i) |=> (base_q == $past(base_q)));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 15,
  parameter int REL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [REL_W-1:0] reload_i,
  output logic             ovf_o
);
  localparam int LOW_W = CNT_W - REL_W;

  logic [CNT_W-1:0] cnt_q;

  assign ovf_o = run_i && tick_i && (&cnt_q) && !load_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i)            cnt_q <= '0;
    else if (load_i)             cnt_q <= {reload_i, {LOW_W{1'b0}}};
    else if (run_i && tick_i)    cnt_q <= cnt_q + 1'b1;
  end

  p_load_value_r4: assert property (@(posedge clk) disable iff (rst)
    (load_i && !clr_i) |=> (cnt_q[LOW_W-1:0] == '0 &&
                            cnt_q[CNT_W-1:LOW_W] == $past(reload_i)));

  p_halt_freeze_r11: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !load_i && !clr_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/wdt_unit.sv
module wdt_unit #(
  parameter int CNT_W    = 15,
  parameter int DATA_W   = 8,
  parameter int BASE_DIV = 12,
  parameter int SLOW_DIV = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wdt_req_o,
  output logic              wdt_cause_o
);
  localparam int REL_W = DATA_W - 1;

  logic             en;
  logic             refresh;
  logic             slow_sel;
  logic [REL_W-1:0] reload;
  logic             run;
  logic             tick;
  logic             ovf;
  logic             req_q;
  logic             cause_q;

  assign run = en && !halt_i;

  wdt_regs #(.DATA_W(DATA_W), .REL_W(REL_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (ovf),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .en_o       (en),
    .refresh_o  (refresh),
    .slow_sel_o (slow_sel),
    .reload_o   (reload)
  );

  wdt_prescaler #(.BASE_DIV(BASE_DIV), .SLOW_DIV(SLOW_DIV)) u_pre (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (ovf || refresh),
    .run_i      (run),
    .slow_sel_i (slow_sel),
    .tick_o     (tick)
  );

  wdt_counter #(.CNT_W(CNT_W), .REL_W(REL_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (ovf),
    .run_i    (run),
    .tick_i   (tick),
    .load_i   (refresh),
    .reload_i (reload),
    .ovf_o    (ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      req_q <= ovf;
      if (ovf) cause_q <= 1'b1;
    end
  end

  assign wdt_req_o   = req_q;
  assign wdt_cause_o = cause_q;

  p_req_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q);

  p_cause_with_req_r9: assert property (@(posedge clk) disable iff (rst)
    req_q |-> cause_q);

  p_cause_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    cause_q |=> cause_q);

  p_ovf_disables_r10: assert property (@(posedge clk) disable iff (rst)
    req_q |-> !en);
endmodule

// File: tb/wdt_unit_bench.sv
module wdt_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       halt_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       wr_sel_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       wdt_req_o;
  logic       wdt_cause_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int mark   = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_unit u_wdt_unit (
    .clk(clk), .rst(rst), .halt_i(halt_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .wdt_req_o(wdt_req_o), .wdt_cause_o(wdt_cause_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic ext_reset();
    @(negedge clk);
    rst = 1'b1; halt_i = 1'b0; wr_en_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_reg(input logic sel, input logic [7:0] data);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic refresh();
    wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_data_i = 8'h02;
    @(negedge clk);
    wr_data_i = 8'h01;
    @(negedge clk);
    wr_en_i = 1'b0;
    mark = cyc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // waits for cyc == target, requiring the request low before, high there, low after
  task automatic expect_ovf(input string req, input int target);
    logic early = 1'b0;
    while (cyc < target) begin
      if (wdt_req_o) early = 1'b1;
      @(negedge clk);
    end
    check({req, " no early request"}, early, 1'b0);
    check({req, " request on overflow cycle"}, wdt_req_o, 1'b1);
    check({req, " cause flag set"}, wdt_cause_o, 1'b1);
    @(negedge clk);
    check({req, "/R8 request one cycle"}, wdt_req_o, 1'b0);
  endtask

  task automatic expect_quiet(input string req, input int n);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdt_req_o) seen = 1'b1;
    end
    check(req, seen, 1'b0);
  endtask

  task automatic t_reset_state();
    ext_reset();
    check("R1 request low after reset", wdt_req_o, 1'b0);
    check("R1 cause low after reset", wdt_cause_o, 1'b0);
    expect_quiet("R1 no request without start", 3500);
  endtask

  task automatic t_fast_timeout();
    ext_reset();
    wr_reg(1'b0, 8'h7F);
    wr_reg(1'b1, 8'h01);
    refresh();
    expect_ovf("R6", mark + 3072);
  endtask

  task automatic t_cannot_stop();
    ext_reset();
    wr_reg(1'b0, 8'h7F);
    wr_reg(1'b1, 8'h01);
    refresh();
    wr_reg(1'b1, 8'h00);  // R3: control write of zero
    wr_reg(1'b0, 8'h00);  // R2: reload change deferred
    expect_ovf("R3/R2", mark + 3072);
  endtask

  task automatic t_dropped_arm();
    ext_reset();
    wr_reg(1'b0, 8'h7F);
    wr_reg(1'b1, 8'h01);
    refresh();
    idle(1000);
    wr_reg(1'b1, 8'h02);
    idle(1);
    wr_reg(1'b1, 8'h01);  // R5: start too late, no reload
    expect_ovf("R5", mark + 3072);
  endtask

  task automatic t_late_refresh();
    ext_reset();
    wr_reg(1'b0, 8'h7F);
    wr_reg(1'b1, 8'h01);
    refresh();
    idle(2000);
    refresh();  // R4: valid refresh restarts the period
    expect_ovf("R4", mark + 3072);
  endtask

  task automatic t_halt();
    ext_reset();
    wr_reg(1'b0, 8'h7F);
    wr_reg(1'b1, 8'h01);
    refresh();
    idle(100);
    halt_i = 1'b1;
    idle(500);
    halt_i = 1'b0;
    expect_ovf("R11", mark + 3072 + 500);
  endtask

  task automatic t_race();
    ext_reset();
    wr_reg(1'b0, 8'h7F);
    wr_reg(1'b1, 8'h01);
    refresh();
    idle(3070);
    refresh();  // R12: start write captured on overflow edge
    check("R12 refresh landed on overflow edge", (mark == cyc), 1'b1);
    check("R12 no request on collision", wdt_req_o, 1'b0);
    check("R12 cause still low", wdt_cause_o, 1'b0);
    expect_ovf("R12", mark + 3072);
  endtask

  task automatic t_after_ovf();
    ext_reset();
    wr_reg(1'b0, 8'h7F);
    wr_reg(1'b1, 8'h01);
    refresh();
    expect_ovf("R8", mark + 3072);
    expect_quiet("R10 no request after overflow", 4000);
    check("R9 cause sticky", wdt_cause_o, 1'b1);
    wr_reg(1'b1, 8'h01);
    refresh();  // reload was cleared to 0: full-length period
    expect_quiet("R10 reload cleared by overflow", 4000);
    check("R9 cause still set", wdt_cause_o, 1'b1);
    ext_reset();
    check("R9 cause cleared by external reset", wdt_cause_o, 1'b0);
  endtask

  task automatic t_slow();
    ext_reset();
    wr_reg(1'b0, 8'hFF);
    wr_reg(1'b1, 8'h01);
    refresh();
    expect_ovf("R7", mark + 49152);
  endtask

  logic done = 1'b0;

  initial begin
    t_reset_state();
    t_fast_timeout();
    t_cannot_stop();
    t_dropped_arm();
    t_late_refresh();
    t_halt();
    t_race();
    t_after_ovf();
    t_slow();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, got cycle %0d expected completion", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule